// File: doc/BRIEF.md
# Majority-Gate Two-Bit Ripple Adder

This block adds two unsigned operands of `WIDTH` bits and returns a `WIDTH+1`-bit result. The top bit is the carry-out. Every gate is a three-input majority function or an inverter. A two-input AND is a majority gate with one input tied to 0, and a two-input OR is a majority gate with one input tied to 1. The carry chain is a row of identical two-bit carry stages. Each stage moves its incoming carry two bit positions forward through one majority level, so the chain is about half as deep as a per-bit full-adder ripple.

The lowest stage has a constant zero carry-in, so it is reduced to a generate term and one majority gate. A separate sum stage builds each sum bit from the operand bits, the carry into that bit and the carry out of it. It uses two majority gates and one inverter per bit. From a generate at bit 0 to the top sum bit, the critical path is `WIDTH/2 + 3` majority gates and one inverter.

The parameter `OUT_REG` picks the output style. When it is 0 the result is purely combinational. When it is 1 the result is captured on the rising clock edge, with a synchronous active-low clear. `WIDTH` must be even and at least 2; any other value stops elaboration.

Top module: `mg_ripple_adder`

## Requirements
- R1: `sum_out` equals the unsigned sum of `op_a` and `op_b` as a `WIDTH+1`-bit value. Bit `WIDTH` is the carry-out.
- R2: When both operands are all ones, the result is `2^(WIDTH+1) - 2`, with the carry-out set.
- R3: A carry generated at bit 0 and propagated through every higher bit reaches the carry-out. For example, `op_a = 1` and `op_b = 2^WIDTH - 1` give exactly `2^WIDTH`.
- R4: With `OUT_REG = 1`, new operands appear on `sum_out` only after the next rising clock edge. Until that edge, `sum_out` keeps the earlier result.
- R5: With `OUT_REG = 1`, a rising edge while `rst_n` is low sets `sum_out` to zero, whatever the operands are.
- R6: With `OUT_REG = 0`, `sum_out` follows the operands with no clock edge, and `rst_n` has no effect on it.
- R7: A bit position where both operand bits are 0 stops the carry, so the next position gets no carry in. A position where both bits are 1 always sends a carry to the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the registered result |
| rst_n | input | 1 | Synchronous active-low clear of the registered result |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum_out | output | WIDTH+1 | Sum, with the carry-out in the top bit |

## Verification
In combinational mode the result is due in the same cycle as the operands. The bench reads it 1 ns after driving them at the falling edge, with no clock edge in between. In registered mode the result is due at the first rising edge after the operands change. The bench reads the output once just before that edge, to confirm the old value is held, and once 1 ns after it. The clear is checked at the edge that follows a low `rst_n`, while the combinational instance is checked for being unaffected during the same window.

// File: rtl/mg_adder_pkg.sv
package mg_adder_pkg;

  // Three-input majority: the only two-input-plus logic primitive of the block.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // AND formed from a majority gate with one leg tied low.
  function automatic logic m_and(input logic x, input logic y);
    return maj3(x, y, 1'b0);
  endfunction

  // OR formed from a majority gate with one leg tied high.
  function automatic logic m_or(input logic x, input logic y);
    return maj3(x, y, 1'b1);
  endfunction

endpackage

// File: rtl/mg_maj3.sv
module mg_maj3 (
  input  logic in_x,
  input  logic in_y,
  input  logic in_z,
  output logic out_m
);
  import mg_adder_pkg::*;

  always_comb out_m = maj3(in_x, in_y, in_z);

endmodule

// File: rtl/mg_carry_pair.sv
// Two-bit carry stage: carry enters at bit lo, leaves two positions higher
// through a single majority level.
module mg_carry_pair (
  input  logic a_lo,
  input  logic b_lo,
  input  logic a_hi,
  input  logic b_hi,
  input  logic cy_in,
  output logic cy_mid,
  output logic cy_out
);
  logic prop_lo;
  logic gen_lo;
  logic look_g;
  logic look_p;

  // prop = a OR b, gen = a AND b, each as one majority gate
  mg_maj3 u_prop (.in_x(a_lo), .in_y(b_lo), .in_z(1'b1), .out_m(prop_lo));
  mg_maj3 u_gen  (.in_x(a_lo), .in_y(b_lo), .in_z(1'b0), .out_m(gen_lo));

  // carry into the upper bit of the pair
  mg_maj3 u_mid  (.in_x(prop_lo), .in_y(gen_lo), .in_z(cy_in), .out_m(cy_mid));

  // look-ahead terms that do not depend on the incoming carry
  mg_maj3 u_lkg  (.in_x(a_hi), .in_y(b_hi), .in_z(gen_lo),  .out_m(look_g));
  mg_maj3 u_lkp  (.in_x(a_hi), .in_y(b_hi), .in_z(prop_lo), .out_m(look_p));

  // the only gate on the carry path through this stage
  mg_maj3 u_out  (.in_x(look_g), .in_y(look_p), .in_z(cy_in), .out_m(cy_out));

endmodule

// File: rtl/mg_carry_pair_lsb.sv
// Lowest two-bit carry stage: carry-in is a constant zero, so the propagate
// term of bit 0 is never needed.
module mg_carry_pair_lsb (
  input  logic a_lo,
  input  logic b_lo,
  input  logic a_hi,
  input  logic b_hi,
  output logic cy_mid,
  output logic cy_out
);
  logic gen_lo;

  mg_maj3 u_gen (.in_x(a_lo), .in_y(b_lo), .in_z(1'b0),   .out_m(gen_lo));
  mg_maj3 u_out (.in_x(a_hi), .in_y(b_hi), .in_z(gen_lo), .out_m(cy_out));

  always_comb cy_mid = gen_lo;

endmodule

// File: rtl/mg_sum_bit.sv
// Sum bit from the carry into and out of the position:
// s = M(~co, M(x, y, ~co), ci), two majority gates and one inverter.
module mg_sum_bit (
  input  logic op_x,
  input  logic op_y,
  input  logic cy_in,
  input  logic cy_out,
  output logic sum_bit
);
  logic cy_out_n;
  logic inner_m;

  always_comb cy_out_n = ~cy_out;

  mg_maj3 u_inner (.in_x(op_x),     .in_y(op_y),    .in_z(cy_out_n), .out_m(inner_m));
  mg_maj3 u_outer (.in_x(cy_out_n), .in_y(inner_m), .in_z(cy_in),    .out_m(sum_bit));

endmodule

// File: rtl/mg_ripple_adder.sv
module mg_ripple_adder #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH:0]   sum_out
);
  localparam int PAIRS = WIDTH / 2;
  localparam int RES_W = WIDTH + 1;

  generate
    if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
      $fatal(1, "mg_ripple_adder: WIDTH must be even and at least 2");
    end
  endgenerate

  // carry_w[i] is the carry into bit i; carry_w[WIDTH] is the carry-out
  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] sum_bits;
  logic [RES_W-1:0] sum_comb;

  always_comb carry_w[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < PAIRS; k++) begin : g_pair
      if (k == 0) begin : g_lsb
        mg_carry_pair_lsb u_pair (
          .a_lo   (op_a[0]),
          .b_lo   (op_b[0]),
          .a_hi   (op_a[1]),
          .b_hi   (op_b[1]),
          .cy_mid (carry_w[1]),
          .cy_out (carry_w[2])
        );
      end else begin : g_mid
        mg_carry_pair u_pair (
          .a_lo   (op_a[2*k]),
          .b_lo   (op_b[2*k]),
          .a_hi   (op_a[2*k+1]),
          .b_hi   (op_b[2*k+1]),
          .cy_in  (carry_w[2*k]),
          .cy_mid (carry_w[2*k+1]),
          .cy_out (carry_w[2*k+2])
        );
      end
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_sum
      mg_sum_bit u_sum (
        .op_x    (op_a[i]),
        .op_y    (op_b[i]),
        .cy_in   (carry_w[i]),
        .cy_out  (carry_w[i+1]),
        .sum_bit (sum_bits[i])
      );
    end
  endgenerate

  always_comb sum_comb = {carry_w[WIDTH], sum_bits};

  generate
    if (OUT_REG) begin : g_reg
      logic [RES_W-1:0] sum_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_comb;
      end
      always_comb sum_out = sum_q;
    end else begin : g_comb
      always_comb sum_out = sum_comb;
    end
  endgenerate

endmodule

// File: rtl/mg_ripple_adder_chk.sv
module mg_ripple_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH:0]   carry_w,
  input logic [WIDTH:0]   sum_out
);
  logic [WIDTH:0] ref_now;
  logic [WIDTH:0] ref_q;
  logic [WIDTH:0] ref_obs;

  always_comb ref_now = {1'b0, op_a} + {1'b0, op_b};

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_now;
  end

  always_comb ref_obs = OUT_REG ? ref_q : ref_now;

  // R1: result matches the behavioural sum, with the due latency
  a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    sum_out == ref_obs);

  // R2: two set top operand bits always produce a carry-out
  a_r2_top_pair_carries: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[WIDTH-1] && op_b[WIDTH-1]) |-> carry_w[WIDTH]);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pos
      // R7: a generating position drives a carry into the next one
      a_r7_gen_sets_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a[i] && op_b[i]) |-> carry_w[i+1]);
      // R7: a killing position blocks the carry into the next one
      a_r7_kill_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_a[i] && !op_b[i]) |-> !carry_w[i+1]);
    end
    if (OUT_REG) begin : g_reg_chk
      // R5: the first edge after the clear is released still shows zero
      a_r5_clear_visible: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_out == '0));
    end
  endgenerate

endmodule

bind mg_ripple_adder mg_ripple_adder_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_a    (op_a),
  .op_b    (op_b),
  .carry_w (carry_w),
  .sum_out (sum_out)
);

// File: tb/mg_ripple_adder_tb_top.sv
`timescale 1ns/1ps
module mg_ripple_adder_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W:0]   sum_reg;
  logic [W:0]   sum_cmb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mg_ripple_adder #(.WIDTH(W), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_out(sum_reg));

  mg_ripple_adder #(.WIDTH(W), .OUT_REG(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_out(sum_cmb));

  // Independent model: bit-serial addition with integer arithmetic
  function automatic logic [W:0] model_sum(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r;
    int cy;
    cy = 0;
    for (int j = 0; j < W; j++) begin
      int t;
      t = int'(x[j]) + int'(y[j]) + cy;
      r[j] = t[0];
      cy = t / 2;
    end
    r[W] = cy[0];
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check combinational at once, registered
  // just before and just after the next rising edge.
  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] prev;
    @(negedge clk);
    prev = sum_reg;
    op_a = x;
    op_b = y;
    #1;
    check({req, " comb"}, sum_cmb, model_sum(x, y));
    check("R4 hold before edge", sum_reg, prev);
    @(posedge clk);
    #1;
    check({req, " reg"}, sum_reg, model_sum(x, y));
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    op_a = 16'h1234;
    op_b = 16'h4321;
    @(posedge clk);
    #1;
    check("R5 cleared under reset", sum_reg, '0);
    check("R6 comb ignores reset", sum_cmb, model_sum(16'h1234, 16'h4321));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R5 released capture", sum_reg, model_sum(16'h1234, 16'h4321));
  endtask

  task automatic t_corners();
    apply("R1 zero", 16'h0000, 16'h0000);
    apply("R2 all ones", 16'hFFFF, 16'hFFFF);
    check("R2 value", sum_reg, 17'h1FFFE);
    apply("R3 gen bit0 full ripple", 16'h0001, 16'hFFFF);
    check("R3 value", sum_reg, 17'h10000);
    apply("R3 mirror", 16'hFFFF, 16'h0001);
    apply("R7 kill stops ripple", 16'h00FF, 16'h0001);
    check("R7 value", sum_reg, 17'h00100);
    apply("R7 gen mid odd bit", 16'h0020, 16'h0020);
    apply("R7 alternating", 16'hAAAA, 16'h5555);
    apply("R1 max plus zero", 16'hFFFF, 16'h0000);
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      apply("R1 random", W'($urandom), W'($urandom));
    end
  endtask

  task automatic t_midrun_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_a = 16'h8000;
    op_b = 16'h8001;
    #1;
    check("R6 comb live during reset", sum_cmb, 17'h10001);
    @(posedge clk);
    #1;
    check("R5 midrun clear", sum_reg, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R5 resume", sum_reg, 17'h10001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset state", sum_reg, '0);
    t_reset_state();
    t_corners();
    t_random();
    t_midrun_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule